// File: doc/BRIEF.md
# Dual-Page Serial Configuration Target

This block is a two-wire serial target that exposes a 512-byte register space as two 256-byte pages. The controller picks a page by the device address it sends: the base address 50h (byte A0h/A1h) opens the lower page and 51h (byte A2h/A3h) opens the upper page. A single byte-address then sets an internal pointer. Data bytes that follow are written to, or read from, consecutive locations. The pointer wraps inside the current page.

Most of the space is nonvolatile user storage, modelled as a plain register array that keeps its contents across reset. A global write-protect input guards that storage. Some locations have special roles. On the lower page, three stored configuration bytes are presented on output pins. Two bytes are reserved. A six-byte window is passed through to an attached port controller as single-cycle read and write strobes. On the upper page, the top sixteen bytes are reserved. Location 6Eh either holds storage or, when the stored mode bit is set, shows the live loss-of-signal input.

The bus pins are sampled by the system clock, so SCL must stay well below a quarter of the clock rate. The SDA output is an open-drain enable: 1 pulls the line low.

Top module: `dual_page_i2c_target`

## Requirements
- R1: A write to device byte A0h or A2h, or a read from A1h or A3h, is acknowledged. Every address byte and data byte written after it is also acknowledged. Any other device byte gets no acknowledge, and the target leaves SDA undriven.
- R2: Written data bytes go to consecutive locations starting at the byte address. The pointer wraps from FFh to 00h inside the selected page and never crosses into the other page.
- R3: A read returns consecutive bytes from the pointer for as long as the controller acknowledges. After the controller's NACK, the target releases SDA.
- R4: Lower-page 78h–79h and upper-page F0h–FFh read as FFh. Writes to them are acknowledged and discarded.
- R5: Lower-page 7Ah–7Fh belong to the port controller. A write gives a one-cycle `ctl_wr` with `ctl_sel` = address − 7Ah and the byte on `ctl_wdata`. A read gives a one-cycle `ctl_rd` with the same select and returns `ctl_rdata`. Write-protect has no effect here.
- R6: While `wp` is high, writes to nonvolatile locations are acknowledged and discarded.
- R7: Bit 0 of stored lower-page byte 75h drives `sff_on`. Stored bytes 76h and 77h appear on `boot_cfg0` and `boot_cfg1`.
- R8: With `sff_on` low, upper-page 6Eh is ordinary storage. With it high, 6Eh reads {7'b0, `los`} and writes to it are discarded.
- R9: Out of reset, SDA is undriven and neither controller strobe is active.
- R10: The pointer is kept across a repeated START and across STOP. A read that sends no byte address continues from where the last access ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| wp | input | 1 | Write-protect for nonvolatile storage |
| los | input | 1 | Live loss-of-signal level |
| ctl_wr | output | 1 | Port-controller write strobe |
| ctl_rd | output | 1 | Port-controller read strobe |
| ctl_sel | output | 3 | Port-controller register select |
| ctl_wdata | output | 8 | Port-controller write data |
| ctl_rdata | input | 8 | Port-controller read data for `ctl_sel` |
| sff_on | output | 1 | Stored status-mode bit |
| boot_cfg0 | output | 8 | Stored configuration byte 76h |
| boot_cfg1 | output | 8 | Stored configuration byte 77h |

## Verification
The bench goes after the following corner cases:
- **Pointer wrap.** It writes across the FFh boundary of the lower page and confirms that upper-page 00h is unchanged. A design that carried the pointer into the ninth address bit would overwrite the other page.
- **Unwritable locations.** It writes to reserved bytes, to 6Eh in status mode, and to storage under write-protect. A design that dropped the acknowledge would stall the controller. One that stored the byte would read it back.
- **Port-controller window under write-protect.** It checks that this window still writes. A wrong protect decode would lose controller writes.
- **Pointer retention.** It runs current-address reads after STOP. An off-by-one on the read increment would return the neighbouring byte.
- **Bus release after NACK.** It checks that SDA is free after the controller's final NACK. A design that kept driving would block the STOP.

// File: rtl/dmap_pkg.sv
// Shared types and address constants for the dual-page serial target.
// Assumes a single 8-bit byte address within each 256-byte page.
package dmap_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_RX,
        LS_ACK,
        LS_LOAD,
        LS_TX,
        LS_RACK
    } link_st_t;

    typedef enum logic [1:0] {
        STG_DEV,
        STG_ADDR,
        STG_DATA
    } stage_t;

    localparam logic [7:0] A_MODE    = 8'h75;
    localparam logic [7:0] A_CFG0    = 8'h76;
    localparam logic [7:0] A_CFG1    = 8'h77;
    localparam logic [7:0] A_RSV_LO  = 8'h78;
    localparam logic [7:0] A_RSV_HI  = 8'h79;
    localparam logic [7:0] A_CTL_LO  = 8'h7A;
    localparam logic [7:0] A_CTL_HI  = 8'h7F;
    localparam logic [7:0] A_STAT    = 8'h6E;
    localparam logic [7:0] A_RSV2_LO = 8'hF0;
endpackage

// File: rtl/i2c_tgt_link.sv
// Bit-level serial target: oversamples SCL/SDA, finds START/STOP, shifts
// bytes, handles acknowledges and keeps the byte pointer and page.
// Assumes SCL is slow against clk (each SCL phase lasts several clocks).
module i2c_tgt_link
    import dmap_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = 7'h50
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic              page,
    output logic [BYTE_W-1:0] ptr,
    output logic              wr_pulse,
    output logic [BYTE_W-1:0] wr_data,
    output logic              ld_pulse,
    input  logic [BYTE_W-1:0] rd_byte
);
    localparam logic [3:0] BITS = 4'(BYTE_W);

    logic [2:0]        scl_sr, sda_sr;
    logic              scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;
    link_st_t          st;
    stage_t            stage;
    logic [3:0]        cnt;
    logic [BYTE_W-1:0] shreg, txreg;
    logic              rnw, nack;

    // Synchronise both bus lines into the clock domain; idle bus is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
        end else begin
            scl_sr <= {scl_sr[1:0], scl_i};
            sda_sr <= {sda_sr[1:0], sda_i};
        end
    end

    // Edge and bus-condition detection on the synchronised lines.
    always_comb begin
        scl_s    = scl_sr[1];
        sda_s    = sda_sr[1];
        scl_rise = scl_s & ~scl_sr[2];
        scl_fall = ~scl_s & scl_sr[2];
        start_c  = scl_s & scl_sr[2] & sda_sr[2] & ~sda_s;
        stop_c   = scl_s & scl_sr[2] & ~sda_sr[2] & sda_s;
    end

    assign ld_pulse = (st == LS_LOAD);

    // Protocol sequencer: receive, acknowledge, transmit, pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= LS_IDLE;
            stage    <= STG_DEV;
            cnt      <= '0;
            shreg    <= '0;
            txreg    <= '0;
            rnw      <= 1'b0;
            nack     <= 1'b0;
            page     <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr_pulse <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_pulse <= 1'b0;
            if (start_c) begin
                st     <= LS_RX;
                stage  <= STG_DEV;
                cnt    <= '0;
                sda_oe <= 1'b0;
            end else if (stop_c) begin
                st     <= LS_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    LS_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BYTE_W-2:0], sda_s};
                            cnt   <= cnt + 4'd1;
                        end else if (scl_fall && cnt == BITS) begin
                            case (stage)
                                STG_DEV: begin
                                    if (shreg[7:2] == DEV_BASE[6:1]) begin
                                        page   <= shreg[1];
                                        rnw    <= shreg[0];
                                        sda_oe <= 1'b1;
                                        st     <= LS_ACK;
                                    end else begin
                                        st <= LS_IDLE;
                                    end
                                end
                                STG_ADDR: begin
                                    ptr    <= shreg;
                                    sda_oe <= 1'b1;
                                    st     <= LS_ACK;
                                end
                                default: begin
                                    wr_pulse <= 1'b1;
                                    wr_data  <= shreg;
                                    sda_oe   <= 1'b1;
                                    st       <= LS_ACK;
                                end
                            endcase
                        end
                    end
                    LS_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            cnt    <= '0;
                            if (stage == STG_DEV && rnw) begin
                                st <= LS_LOAD;
                            end else begin
                                st <= LS_RX;
                                if (stage == STG_DEV)       stage <= STG_ADDR;
                                else if (stage == STG_ADDR) stage <= STG_DATA;
                                else                        ptr   <= ptr + 8'd1;
                            end
                        end
                    end
                    LS_LOAD: begin
                        txreg  <= rd_byte;
                        sda_oe <= ~rd_byte[BYTE_W-1];
                        ptr    <= ptr + 8'd1;
                        cnt    <= '0;
                        st     <= LS_TX;
                    end
                    LS_TX: begin
                        if (scl_rise) begin
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (cnt == BITS) begin
                                sda_oe <= 1'b0;
                                st     <= LS_RACK;
                            end else begin
                                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~txreg[BYTE_W-2];
                            end
                        end
                    end
                    LS_RACK: begin
                        if (scl_rise)      nack <= sda_s;
                        else if (scl_fall) st   <= nack ? LS_IDLE : LS_LOAD;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LS_IDLE) |-> !sda_oe);
    assert_drive_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
    assert_ptr_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_pulse && ptr == 8'hFF) |=> (ptr == 8'h00));
endmodule

// File: rtl/dmap_regs.sv
// Address decode and storage for both pages: nonvolatile array, reserved
// bytes, port-controller window and the mode-dependent status byte.
// Assumes the array keeps its contents across reset (no reset on storage).
module dmap_regs
    import dmap_pkg::*;
#(
    parameter int PAGES = 2,
    localparam int DEPTH = PAGES * (1 << BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page,
    input  logic [BYTE_W-1:0] ptr,
    input  logic              wr_pulse,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              ld_pulse,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic              wp,
    input  logic              los,
    output logic              ctl_wr,
    output logic              ctl_rd,
    output logic [2:0]        ctl_sel,
    output logic [BYTE_W-1:0] ctl_wdata,
    input  logic [BYTE_W-1:0] ctl_rdata,
    output logic              sff_on,
    output logic [BYTE_W-1:0] boot_cfg0,
    output logic [BYTE_W-1:0] boot_cfg1
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic              is_ctl, is_rsv, is_stat, nv_we;

    assign sff_on    = mem[{1'b0, A_MODE}][0];
    assign boot_cfg0 = mem[{1'b0, A_CFG0}];
    assign boot_cfg1 = mem[{1'b0, A_CFG1}];

    // Classify the current pointer and build read data and strobes.
    always_comb begin
        is_ctl  = !page && ptr >= A_CTL_LO && ptr <= A_CTL_HI;
        is_rsv  = (!page && (ptr == A_RSV_LO || ptr == A_RSV_HI)) ||
                  (page && ptr >= A_RSV2_LO);
        is_stat = page && ptr == A_STAT && sff_on;
        nv_we   = wr_pulse && !wp && !is_ctl && !is_rsv && !is_stat;
        if (is_rsv)       rd_byte = '1;
        else if (is_ctl)  rd_byte = ctl_rdata;
        else if (is_stat) rd_byte = {{(BYTE_W-1){1'b0}}, los};
        else              rd_byte = mem[{page, ptr}];
        ctl_wr    = wr_pulse && is_ctl;
        ctl_rd    = ld_pulse && is_ctl;
        ctl_sel   = ptr[2:0] - A_CTL_LO[2:0];
        ctl_wdata = wr_data;
    end

    // Store accepted writes into the nonvolatile array.
    always_ff @(posedge clk) begin
        if (nv_we) mem[{page, ptr}] <= wr_data;
    end

    assert_wp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wp |=> ($stable(boot_cfg0) && $stable(boot_cfg1) && $stable(sff_on)));
    assert_ctl_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_wr && ctl_rd));
endmodule

// File: rtl/dual_page_i2c_target.sv
// Top level: joins the serial link engine to the two-page address decoder.
// Assumes an external open-drain pad turns sda_oe into a low on SDA.
module dual_page_i2c_target
    import dmap_pkg::*;
#(
    parameter logic [6:0] DEV_BASE = 7'h50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       wp,
    input  logic       los,
    output logic       ctl_wr,
    output logic       ctl_rd,
    output logic [2:0] ctl_sel,
    output logic [7:0] ctl_wdata,
    input  logic [7:0] ctl_rdata,
    output logic       sff_on,
    output logic [7:0] boot_cfg0,
    output logic [7:0] boot_cfg1
);
    logic              page, wr_pulse, ld_pulse;
    logic [BYTE_W-1:0] ptr, wr_data, rd_byte;

    i2c_tgt_link #(.DEV_BASE(DEV_BASE)) u_link (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_oe(sda_oe), .page(page), .ptr(ptr), .wr_pulse(wr_pulse),
        .wr_data(wr_data), .ld_pulse(ld_pulse), .rd_byte(rd_byte)
    );

    dmap_regs #(.PAGES(2)) u_regs (
        .clk(clk), .rst_n(rst_n), .page(page), .ptr(ptr),
        .wr_pulse(wr_pulse), .wr_data(wr_data), .ld_pulse(ld_pulse),
        .rd_byte(rd_byte), .wp(wp), .los(los), .ctl_wr(ctl_wr),
        .ctl_rd(ctl_rd), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sff_on(sff_on), .boot_cfg0(boot_cfg0),
        .boot_cfg1(boot_cfg1)
    );
endmodule

// File: tb/tb_dual_page_i2c_target.sv
module tb_dual_page_i2c_target;
    localparam int Q = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0, scl = 1'b1, m_low = 1'b0, wp = 1'b0, los = 1'b0;
    logic       sda_oe, ctl_wr, ctl_rd, sff_on;
    logic [2:0] ctl_sel;
    logic [7:0] ctl_wdata, ctl_rdata, boot_cfg0, boot_cfg1;
    wire        sda_bus = ~(m_low | sda_oe);

    dual_page_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .wp(wp), .los(los), .ctl_wr(ctl_wr),
        .ctl_rd(ctl_rd), .ctl_sel(ctl_sel), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sff_on(sff_on), .boot_cfg0(boot_cfg0),
        .boot_cfg1(boot_cfg1)
    );

    // Port-controller model: six registers written by the strobe.
    logic [7:0] ctl_regs [8];
    initial for (int i = 0; i < 8; i++) ctl_regs[i] = 8'h00;
    always @(posedge clk) if (ctl_wr) ctl_regs[ctl_sel] <= ctl_wdata;
    assign ctl_rdata = ctl_regs[ctl_sel];

    int n_tests = 0, n_fail = 0;
    logic [7:0] ref_mem [512];
    bit         ref_ok  [512];
    logic [7:0] ctl_m   [8];
    logic [7:0] wbuf    [8];
    logic [7:0] rbuf    [8];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit sff_m();
        return ref_ok[9'h075] && ref_mem[9'h075][0];
    endfunction

    function automatic void model_write(input bit pg, input logic [7:0] a, input logic [7:0] d);
        if (!pg && a inside {[8'h7A:8'h7F]}) ctl_m[a - 8'h7A] = d;
        else if ((!pg && (a == 8'h78 || a == 8'h79)) || (pg && a >= 8'hF0)) ;
        else if (pg && a == 8'h6E && sff_m()) ;
        else if (!wp) begin
            ref_mem[{pg, a}] = d;
            ref_ok[{pg, a}]  = 1'b1;
        end
    endfunction

    function automatic logic [7:0] exp_read(input bit pg, input logic [7:0] a, output bit known);
        known = 1'b1;
        if ((!pg && (a == 8'h78 || a == 8'h79)) || (pg && a >= 8'hF0)) return 8'hFF;
        if (!pg && a inside {[8'h7A:8'h7F]}) return ctl_m[a - 8'h7A];
        if (pg && a == 8'h6E && sff_m()) return {7'b0, los};
        known = ref_ok[{pg, a}];
        return ref_mem[{pg, a}];
    endfunction

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; qw(); scl = 1'b1; qw(); m_low = 1'b1; qw(); scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; qw(); scl = 1'b1; qw(); m_low = 1'b0; qw();
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0;
        end
        m_low = 1'b0; qw(); scl = 1'b1; qw(); ack = ~sda_bus; qw(); scl = 1'b0; qw();
    endtask

    task automatic rbyte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        b = 8'h00;
        for (int i = 0; i < 8; i++) begin
            qw(); scl = 1'b1; qw(); b = {b[6:0], sda_bus}; qw(); scl = 1'b0;
        end
        m_low = give_ack; qw(); scl = 1'b1; qw(); qw(); scl = 1'b0; qw();
        m_low = 1'b0;
    endtask

    // Device byte, address byte, then n data bytes from wbuf (R1 acks).
    task automatic wr_seq(input bit pg, input logic [7:0] a, input int n);
        bit ack;
        bus_start();
        wbyte({6'b101000, pg, 1'b0}, ack); chk(ack, "R1 dev ack wr", ack, 1);
        wbyte(a, ack);                     chk(ack, "R1 addr ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            wbyte(wbuf[i], ack);           chk(ack, "R1 data ack", ack, 1);
            model_write(pg, a + 8'(i), wbuf[i]);
        end
        bus_stop();
        qw();
    endtask

    // Set pointer, repeated START, read n bytes, compare (R3, R10).
    task automatic rd_seq(input bit pg, input logic [7:0] a, input int n, input string tag);
        bit ack, known;
        logic [7:0] e;
        bus_start();
        wbyte({6'b101000, pg, 1'b0}, ack); chk(ack, "R1 dev ack", ack, 1);
        wbyte(a, ack);                     chk(ack, "R1 addr ack", ack, 1);
        bus_start();
        wbyte({6'b101000, pg, 1'b1}, ack); chk(ack, "R10 dev ack after Sr", ack, 1);
        for (int i = 0; i < n; i++) rbyte(i != n - 1, rbuf[i]);
        chk(sda_oe == 1'b0, "R3 release after NACK", sda_oe, 0);
        bus_stop();
        qw();
        for (int i = 0; i < n; i++) begin
            e = exp_read(pg, a + 8'(i), known);
            if (known) chk(rbuf[i] == e, tag, rbuf[i], e);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit ack, known;
        logic [7:0] b, e;
        for (int i = 0; i < 512; i++) begin ref_ok[i] = 1'b0; ref_mem[i] = 8'h00; end
        for (int i = 0; i < 8; i++) ctl_m[i] = 8'h00;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        chk(sda_oe == 0 && ctl_wr == 0 && ctl_rd == 0, "R9 reset outputs",
            {sda_oe, ctl_wr, ctl_rd}, 0);
        rst_n = 1'b1;
        qw();
        chk(sda_oe == 0, "R9 idle after reset", sda_oe, 0);

        // R7: stored mode and configuration bytes
        wbuf[0] = 8'h00; wbuf[1] = 8'h1F; wbuf[2] = 8'hF0;
        wr_seq(1'b0, 8'h75, 3);
        chk(sff_on == 1'b0, "R7 sff_on off", sff_on, 0);
        chk(boot_cfg0 == 8'h1F, "R7 boot_cfg0", boot_cfg0, 8'h1F);
        chk(boot_cfg1 == 8'hF0, "R7 boot_cfg1", boot_cfg1, 8'hF0);

        // R1: foreign device address gets no acknowledge
        bus_start();
        wbyte(8'hB0, ack);
        chk(!ack, "R1 foreign address NACK", ack, 0);
        chk(sda_oe == 0, "R1 no drive on foreign", sda_oe, 0);
        bus_stop(); qw();

        // R2: wrap inside lower page, upper page 00h untouched
        wbuf[0] = 8'h33; wr_seq(1'b1, 8'h00, 1);
        wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3; wbuf[3] = 8'hA4;
        wr_seq(1'b0, 8'hFE, 4);
        rd_seq(1'b0, 8'hFE, 4, "R2 wrap readback");
        rd_seq(1'b1, 8'h00, 1, "R2 other page untouched");
        chk(rbuf[0] == 8'h33, "R2 page isolation", rbuf[0], 8'h33);

        // R4: reserved bytes
        wbuf[0] = 8'h55; wbuf[1] = 8'hAA; wr_seq(1'b0, 8'h78, 2);
        rd_seq(1'b0, 8'h78, 2, "R4 lower reserved");
        chk(rbuf[0] == 8'hFF && rbuf[1] == 8'hFF, "R4 lower reads FF", rbuf[0], 8'hFF);
        wbuf[0] = 8'h12; wr_seq(1'b1, 8'hF8, 1);
        rd_seq(1'b1, 8'hF8, 1, "R4 upper reserved");
        chk(rbuf[0] == 8'hFF, "R4 upper reads FF", rbuf[0], 8'hFF);

        // R5: port-controller window, with write-protect active
        wp = 1'b1;
        for (int i = 0; i < 6; i++) wbuf[i] = 8'(8'h40 + i * 8'h11);
        wr_seq(1'b0, 8'h7A, 6);
        for (int i = 0; i < 6; i++)
            chk(ctl_regs[i] == ctl_m[i], "R5 controller write", ctl_regs[i], ctl_m[i]);
        rd_seq(1'b0, 8'h7A, 6, "R5 controller read");
        wp = 1'b0;

        // R6: write-protect on storage
        wbuf[0] = 8'h11; wr_seq(1'b0, 8'h10, 1);
        wbuf[0] = 8'h22; wr_seq(1'b1, 8'h20, 1);
        wp = 1'b1;
        wbuf[0] = 8'hEE; wr_seq(1'b0, 8'h10, 1);
        wbuf[0] = 8'hDD; wr_seq(1'b1, 8'h20, 1);
        wbuf[0] = 8'h99; wr_seq(1'b0, 8'h76, 1);
        wp = 1'b0;
        rd_seq(1'b0, 8'h10, 1, "R6 lower protected");
        chk(rbuf[0] == 8'h11, "R6 lower kept", rbuf[0], 8'h11);
        rd_seq(1'b1, 8'h20, 1, "R6 upper protected");
        chk(boot_cfg0 == 8'h1F, "R6 cfg kept", boot_cfg0, 8'h1F);

        // R8: status byte follows the mode bit
        wbuf[0] = 8'hA5; wr_seq(1'b1, 8'h6E, 1);
        rd_seq(1'b1, 8'h6E, 1, "R8 storage when off");
        wbuf[0] = 8'h01; wr_seq(1'b0, 8'h75, 1);
        chk(sff_on == 1'b1, "R7 sff_on set", sff_on, 1);
        los = 1'b1;
        rd_seq(1'b1, 8'h6E, 1, "R8 status los=1");
        chk(rbuf[0] == 8'h01, "R8 status one", rbuf[0], 8'h01);
        los = 1'b0;
        wbuf[0] = 8'h77; wr_seq(1'b1, 8'h6E, 1);
        rd_seq(1'b1, 8'h6E, 1, "R8 status los=0");
        chk(rbuf[0] == 8'h00, "R8 status zero", rbuf[0], 8'h00);
        wbuf[0] = 8'h00; wr_seq(1'b0, 8'h75, 1);
        rd_seq(1'b1, 8'h6E, 1, "R8 storage restored");
        chk(rbuf[0] == 8'hA5, "R8 write discarded", rbuf[0], 8'hA5);

        // R10: current-address read after STOP continues from pointer
        wbuf[0] = 8'hC0; wbuf[1] = 8'hC1; wbuf[2] = 8'hC2; wbuf[3] = 8'hC3;
        wr_seq(1'b0, 8'h40, 4);
        rd_seq(1'b0, 8'h40, 2, "R3 sequential read");
        bus_start();
        wbyte(8'hA1, ack); chk(ack, "R10 dev ack current read", ack, 1);
        rbyte(1'b0, b);
        bus_stop(); qw();
        chk(b == 8'hC2, "R10 current address", b, 8'hC2);

        // Random bursts against the model (R2, R3)
        for (int k = 0; k < 12; k++) begin
            bit pg;
            logic [7:0] a;
            int n;
            pg = 1'($urandom % 2);
            a  = 8'($urandom);
            n  = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            if (!pg && a >= 8'h72 && a <= 8'h75) a = 8'h20;
            wr_seq(pg, a, n);
            rd_seq(pg, a, n, "R2 random burst readback");
        end

        e = exp_read(1'b0, 8'h41, known);
        rd_seq(1'b0, 8'h41, 1, "R3 single read");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule